// File: doc/BRIEF.md
# Key-Gated Block DMA Control Registers

This block is the register file and transfer sequencer for a cartridge-side DMA engine. A host reaches it through 32-bit word accesses at byte offsets. Only the low 16 bits carry register data. On every read while unlocked, the high 16 bits mirror the status word. All registers stay closed until a magic value is written to the key register. Software first sets a block count and a start address, then writes a direction code to the command register. The sequencer then moves bytes between one of two byte streams (an SD-side stream and a USB-side stream) and a byte-wide memory port. While it runs it reports busy, and it reports a timeout if the stream stalls.

Transfer size is counted in blocks of 2^BLK_LOG2 bytes, minus one. The default block is 512 bytes. The start address is counted in units of 2^UNIT_LOG2 bytes, 2048 by default.

Streams use valid/ready. A byte moves on a clock edge where both are high. An inbound source may hold valid low for as long as it likes, which stalls the transfer. An outbound sink may hold ready low, and the block then keeps valid high and the data stable until the sink accepts. The memory port writes in the same cycle that an inbound byte is accepted. A read returns data one cycle after mem_re.

Top module: `cart_dma_ctrl`

## Requirements
- R1: After reset the registers are locked, the status busy and timeout bits are 0, and every read returns 0.
- R2: Writing 0x1234 to the low half at offset 0x20 unlocks the registers. Writing 0 there locks them. Any other value leaves the lock state unchanged.
- R3: While locked, writes to any offset other than 0x20 have no effect, and reads return 0 on all 32 bits.
- R4: While unlocked, read bits 31:16 equal the status word at every offset. Offsets 0x08 (length) and 0x0C (start address) read back their last written low 16 bits. Offset 0x2C reads major version in bits 15:8 and minor version in bits 7:0, and writes to it have no effect.
- R5: The status word (offset 0x04, low half) has bit 0 = busy, bit 1 = timeout, bit 2 = usb_txe_n, bit 3 = usb_rxf_n, and all other bits 0.
- R6: Command values written to offset 0x14 are 1 (SD stream to memory), 2 (memory to SD stream), 3 (USB stream to memory) and 4 (memory to USB stream). Any other value starts nothing and leaves the timeout bit unchanged.
- R7: A transfer moves exactly (length+1)·2^BLK_LOG2 bytes.
- R8: The first byte uses memory address start·2^UNIT_LOG2. Each following byte uses the next address.
- R9: In an inbound transfer, only the selected source sees ready. Each accepted byte is written to memory in the same cycle with its data. All other stream ready and valid outputs stay 0.
- R10: In an outbound transfer, the selected sink gets the memory byte at the current address. Valid and data stay stable until ready.
- R11: Busy reads 1 from the cycle after an accepted command until the edge on which the last byte is transferred, and reads 0 after that edge.
- R12: If TIMEOUT consecutive running cycles pass with no byte transferred, the transfer aborts on the last of them. Busy then goes to 0, timeout goes to 1, and no further stream ready or memory write occurs.
- R13: An accepted command clears the timeout bit. A command written while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the accessed register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| usb_rxf_n | input | 1 | USB receive FIFO empty flag, low when host data waits |
| usb_txe_n | input | 1 | USB transmit FIFO full flag, low when sending is possible |
| sd_rx_valid | input | 1 | SD source byte valid |
| sd_rx_data | input | 8 | SD source byte |
| sd_rx_ready | output | 1 | Block accepts SD source byte |
| sd_tx_valid | output | 1 | Byte toward SD sink valid |
| sd_tx_data | output | 8 | Byte toward SD sink |
| sd_tx_ready | input | 1 | SD sink accepts byte |
| usb_rx_valid | input | 1 | USB source byte valid |
| usb_rx_data | input | 8 | USB source byte |
| usb_rx_ready | output | 1 | Block accepts USB source byte |
| usb_tx_valid | output | 1 | Byte toward USB sink valid |
| usb_tx_data | output | 8 | Byte toward USB sink |
| usb_tx_ready | input | 1 | USB sink accepts byte |
| mem_we | output | 1 | Memory byte write enable |
| mem_re | output | 1 | Memory byte read request, data next cycle |
| mem_addr | output | 16+UNIT_LOG2 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, one cycle after mem_re |

## Verification
The hardest situation to reach is an abort in the middle of a block. It needs a transfer that has started and moved a few bytes, and then a stall of exactly the right length, so that the cycle where busy drops can be pinned down. The stimulus does this by driving a source with a byte budget. The source stops after a handful of bytes, and the bench then counts idle edges one by one. It checks that busy still holds one edge before the limit and has fallen at the limit, that the timeout bit is set, and that a still-valid source is no longer accepted. The same sequence then restarts the transfer and writes a second command while the first is busy, to show that the second command is ignored.

// File: rtl/cdma_pkg.sv
package cdma_pkg;
  typedef enum logic [2:0] {
    DIR_NONE    = 3'd0,
    DIR_SD2MEM  = 3'd1,
    DIR_MEM2SD  = 3'd2,
    DIR_USB2MEM = 3'd3,
    DIR_MEM2USB = 3'd4
  } dir_e;

  localparam logic [7:0]  OFS_STATUS = 8'h04;
  localparam logic [7:0]  OFS_LEN    = 8'h08;
  localparam logic [7:0]  OFS_BASE   = 8'h0C;
  localparam logic [7:0]  OFS_CMD    = 8'h14;
  localparam logic [7:0]  OFS_KEY    = 8'h20;
  localparam logic [7:0]  OFS_VER    = 8'h2C;
  localparam logic [15:0] KEY_OPEN   = 16'h1234;
  localparam logic [15:0] KEY_SHUT   = 16'h0000;

  function automatic logic dir_inbound(dir_e d);
    return (d == DIR_SD2MEM) || (d == DIR_USB2MEM);
  endfunction

  function automatic logic dir_uses_sd(dir_e d);
    return (d == DIR_SD2MEM) || (d == DIR_MEM2SD);
  endfunction
endpackage

// File: rtl/cdma_regs.sv
module cdma_regs
  import cdma_pkg::*;
#(
  parameter logic [7:0] VER_MAJ = 8'd3,
  parameter logic [7:0] VER_MIN = 8'd4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr,
  input  logic [7:0]  addr,
  input  logic [31:0] wdata,
  input  logic        busy,
  input  logic [15:0] status,
  output logic [31:0] rdata,
  output logic        unlocked,
  output logic [15:0] len_q,
  output logic [15:0] base_q,
  output logic        start,
  output dir_e        start_dir
);
  logic [15:0] wlo;
  logic        code_ok;
  logic [15:0] rd_lo;

  assign wlo       = wdata[15:0];
  assign code_ok   = (wlo >= 16'd1) && (wlo <= 16'd4);
  assign start     = wr && unlocked && (addr == OFS_CMD) && code_ok && !busy;
  assign start_dir = dir_e'(wlo[2:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      len_q    <= '0;
      base_q   <= '0;
    end else if (wr) begin
      if (addr == OFS_KEY) begin
        if (wlo == KEY_OPEN)      unlocked <= 1'b1;
        else if (wlo == KEY_SHUT) unlocked <= 1'b0;
      end
      if (unlocked && addr == OFS_LEN)  len_q  <= wlo;
      if (unlocked && addr == OFS_BASE) base_q <= wlo;
    end
  end

  always_comb begin
    case (addr)
      OFS_STATUS: rd_lo = status;
      OFS_LEN:    rd_lo = len_q;
      OFS_BASE:   rd_lo = base_q;
      OFS_VER:    rd_lo = {VER_MAJ, VER_MIN};
      default:    rd_lo = '0;
    endcase
    rdata = unlocked ? {status, rd_lo} : 32'd0;
  end

  // R3
  locked_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && wr) |=> ($stable(len_q) && $stable(base_q)));
endmodule

// File: rtl/cdma_seq.sv
module cdma_seq
  import cdma_pkg::*;
#(
  parameter int BLK_LOG2  = 9,
  parameter int UNIT_LOG2 = 11,
  parameter int TIMEOUT   = 1024,
  parameter int MEM_AW    = 16 + UNIT_LOG2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  dir_e              start_dir,
  input  logic [15:0]       len,
  input  logic [15:0]       base,
  output logic              busy,
  output logic              tout,
  input  logic              sd_rx_valid,
  input  logic [7:0]        sd_rx_data,
  output logic              sd_rx_ready,
  output logic              sd_tx_valid,
  output logic [7:0]        sd_tx_data,
  input  logic              sd_tx_ready,
  input  logic              usb_rx_valid,
  input  logic [7:0]        usb_rx_data,
  output logic              usb_rx_ready,
  output logic              usb_tx_valid,
  output logic [7:0]        usb_tx_data,
  input  logic              usb_tx_ready,
  output logic              mem_we,
  output logic              mem_re,
  output logic [MEM_AW-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata
);
  localparam int CNT_W = 17 + BLK_LOG2;
  localparam int TO_W  = (TIMEOUT > 2) ? $clog2(TIMEOUT) : 1;
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TIMEOUT - 1);

  dir_e              dir_q;
  logic [MEM_AW-1:0] addr_q;
  logic [CNT_W-1:0]  left_q;
  logic [TO_W-1:0]   idle_q;
  logic [7:0]        hold_q;
  logic              hold_v_q, rd_pend_q;

  logic       inbound, use_sd, in_valid, in_ready, out_valid, out_ready;
  logic [7:0] in_data;
  logic       hs, last, tout_hit;

  assign inbound   = dir_inbound(dir_q);
  assign use_sd    = dir_uses_sd(dir_q);
  assign in_valid  = use_sd ? sd_rx_valid : usb_rx_valid;
  assign in_data   = use_sd ? sd_rx_data  : usb_rx_data;
  assign out_ready = use_sd ? sd_tx_ready : usb_tx_ready;
  assign in_ready  = busy && inbound;
  assign out_valid = busy && !inbound && hold_v_q;

  assign sd_rx_ready  = in_ready && use_sd;
  assign usb_rx_ready = in_ready && !use_sd;
  assign sd_tx_valid  = out_valid && use_sd;
  assign usb_tx_valid = out_valid && !use_sd;
  assign sd_tx_data   = hold_q;
  assign usb_tx_data  = hold_q;

  assign hs        = inbound ? (in_valid && in_ready) : (out_valid && out_ready);
  assign mem_we    = in_ready && in_valid;
  assign mem_wdata = in_data;
  assign mem_addr  = addr_q;
  assign mem_re    = busy && !inbound && !hold_v_q && !rd_pend_q;
  assign last      = (left_q == CNT_W'(1));
  assign tout_hit  = busy && !hs && (idle_q == TO_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      tout      <= 1'b0;
      dir_q     <= DIR_NONE;
      addr_q    <= '0;
      left_q    <= '0;
      idle_q    <= '0;
      hold_q    <= '0;
      hold_v_q  <= 1'b0;
      rd_pend_q <= 1'b0;
    end else if (start) begin
      busy      <= 1'b1;
      tout      <= 1'b0;
      dir_q     <= start_dir;
      addr_q    <= MEM_AW'(base) << UNIT_LOG2;
      left_q    <= (CNT_W'(len) + CNT_W'(1)) << BLK_LOG2;
      idle_q    <= '0;
      hold_v_q  <= 1'b0;
      rd_pend_q <= 1'b0;
    end else if (busy) begin
      rd_pend_q <= mem_re;
      if (rd_pend_q) begin
        hold_q   <= mem_rdata;
        hold_v_q <= 1'b1;
      end
      if (hs) begin
        addr_q   <= addr_q + 1'b1;
        left_q   <= left_q - 1'b1;
        idle_q   <= '0;
        hold_v_q <= 1'b0;
        if (last) busy <= 1'b0;
      end else if (tout_hit) begin
        busy <= 1'b0;
        tout <= 1'b1;
      end else begin
        idle_q <= idle_q + 1'b1;
      end
    end
  end

  // R9
  one_stream_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sd_rx_ready, usb_rx_ready, sd_tx_valid, usb_tx_valid}));

  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hs && !last) |=> (mem_addr == $past(mem_addr) + 1'b1));

  // R10
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sd_tx_valid && !sd_tx_ready) |=> ((sd_tx_valid && $stable(sd_tx_data)) || !busy));

  // R11
  done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && hs && last) |=> !busy);

  // R12
  tout_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tout) |-> $fell(busy));
endmodule

// File: rtl/cart_dma_ctrl.sv
module cart_dma_ctrl
  import cdma_pkg::*;
#(
  parameter int          BLK_LOG2  = 9,
  parameter int          UNIT_LOG2 = 11,
  parameter int          TIMEOUT   = 1024,
  parameter logic [7:0]  VER_MAJ   = 8'd3,
  parameter logic [7:0]  VER_MIN   = 8'd4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic                    usb_rxf_n,
  input  logic                    usb_txe_n,
  input  logic                    sd_rx_valid,
  input  logic [7:0]              sd_rx_data,
  output logic                    sd_rx_ready,
  output logic                    sd_tx_valid,
  output logic [7:0]              sd_tx_data,
  input  logic                    sd_tx_ready,
  input  logic                    usb_rx_valid,
  input  logic [7:0]              usb_rx_data,
  output logic                    usb_rx_ready,
  output logic                    usb_tx_valid,
  output logic [7:0]              usb_tx_data,
  input  logic                    usb_tx_ready,
  output logic                    mem_we,
  output logic                    mem_re,
  output logic [16+UNIT_LOG2-1:0] mem_addr,
  output logic [7:0]              mem_wdata,
  input  logic [7:0]              mem_rdata
);
  localparam int MEM_AW = 16 + UNIT_LOG2;

  logic        busy, tout, unlocked, start;
  logic [15:0] len_q, base_q, status;
  dir_e        start_dir;

  assign status = {12'd0, usb_rxf_n, usb_txe_n, tout, busy};

  cdma_regs #(.VER_MAJ(VER_MAJ), .VER_MIN(VER_MIN)) i_regs (
    .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .busy(busy), .status(status), .rdata(bus_rdata), .unlocked(unlocked),
    .len_q(len_q), .base_q(base_q), .start(start), .start_dir(start_dir)
  );

  cdma_seq #(.BLK_LOG2(BLK_LOG2), .UNIT_LOG2(UNIT_LOG2), .TIMEOUT(TIMEOUT),
             .MEM_AW(MEM_AW)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dir(start_dir),
    .len(len_q), .base(base_q), .busy(busy), .tout(tout),
    .sd_rx_valid(sd_rx_valid), .sd_rx_data(sd_rx_data), .sd_rx_ready(sd_rx_ready),
    .sd_tx_valid(sd_tx_valid), .sd_tx_data(sd_tx_data), .sd_tx_ready(sd_tx_ready),
    .usb_rx_valid(usb_rx_valid), .usb_rx_data(usb_rx_data), .usb_rx_ready(usb_rx_ready),
    .usb_tx_valid(usb_tx_valid), .usb_tx_data(usb_tx_data), .usb_tx_ready(usb_tx_ready),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  // R13
  busy_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);

  // R3
  locked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |-> !start);
endmodule

// File: tb/test_cart_dma_ctrl.sv
`timescale 1ns/1ps
module test_cart_dma_ctrl;
  localparam int BLK  = 3;
  localparam int UNIT = 5;
  localparam int TO   = 12;
  localparam int AW   = 16 + UNIT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_wr = 1'b0;
  logic [7:0]    bus_addr = 8'h00;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic          usb_rxf_n = 1'b1, usb_txe_n = 1'b0;
  logic          sd_rx_valid = 1'b0, usb_rx_valid = 1'b0;
  logic [7:0]    sd_rx_data = '0, usb_rx_data = '0;
  logic          sd_tx_ready = 1'b0, usb_tx_ready = 1'b0;
  logic          sd_rx_ready, usb_rx_ready, sd_tx_valid, usb_tx_valid;
  logic [7:0]    sd_tx_data, usb_tx_data;
  logic          mem_we, mem_re;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_wdata;
  logic [7:0]    mem_rdata = '0;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  cart_dma_ctrl #(.BLK_LOG2(BLK), .UNIT_LOG2(UNIT), .TIMEOUT(TO),
                  .VER_MAJ(8'd3), .VER_MIN(8'd4)) i_cart_dma_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .usb_rxf_n(usb_rxf_n), .usb_txe_n(usb_txe_n),
    .sd_rx_valid(sd_rx_valid), .sd_rx_data(sd_rx_data), .sd_rx_ready(sd_rx_ready),
    .sd_tx_valid(sd_tx_valid), .sd_tx_data(sd_tx_data), .sd_tx_ready(sd_tx_ready),
    .usb_rx_valid(usb_rx_valid), .usb_rx_data(usb_rx_data), .usb_rx_ready(usb_rx_ready),
    .usb_tx_valid(usb_tx_valid), .usb_tx_data(usb_tx_data), .usb_tx_ready(usb_tx_ready),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] mem_at(int a);
    return 8'((a & 8'hFF) ^ ((a >> 8) & 8'hFF)) + 8'h3C;
  endfunction

  function automatic logic [7:0] pat(int dir, int i);
    return 8'(i * 7 + dir * 16 + 1);
  endfunction

  always @(posedge clk) if (mem_re) mem_rdata <= mem_at(int'(mem_addr));

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'h04;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  function automatic logic [15:0] stat(logic b, logic t);
    return {12'd0, usb_rxf_n, usb_txe_n, t, b};
  endfunction

  // inbound feed of count bytes starting at byte index first
  task automatic feed_in(int dir, int first, int count, int ba);
    int i = first;
    int cyc = 0;
    logic [31:0] r;
    while (i < first + count && cyc < 2000) begin
      logic v;
      logic rdy;
      v = (cyc % 3) != 2;
      if (dir == 1) begin sd_rx_valid = v; sd_rx_data = pat(dir, i); end
      else begin usb_rx_valid = v; usb_rx_data = pat(dir, i); end
      #0.5;
      rdy = (dir == 1) ? sd_rx_ready : usb_rx_ready;
      chk("R9 other ready low", (dir == 1) ? usb_rx_ready : sd_rx_ready, 0);
      if (v && rdy) begin
        chk("R9 mem_we", mem_we, 1);
        chk("R8 mem_addr", mem_addr, ba + i);
        chk("R9 mem_wdata", mem_wdata, pat(dir, i));
        rd(8'h04, r);
        chk("R11 busy during transfer", r[0], 1);
        i++;
      end
      @(negedge clk);
      cyc++;
    end
    sd_rx_valid = 1'b0; usb_rx_valid = 1'b0;
    chk("R7 bytes accepted", i, first + count);
  endtask

  task automatic drain_out(int dir, int count, int ba);
    int i = 0;
    int cyc = 0;
    while (i < count && cyc < 4000) begin
      logic rdy;
      logic v;
      rdy = (cyc % 4) != 1;
      if (dir == 2) sd_tx_ready = rdy; else usb_tx_ready = rdy;
      #0.5;
      v = (dir == 2) ? sd_tx_valid : usb_tx_valid;
      chk("R9 no inbound ready", {sd_rx_ready, usb_rx_ready, mem_we}, 0);
      if (v && rdy) begin
        chk("R10 tx data", (dir == 2) ? sd_tx_data : usb_tx_data, mem_at(ba + i));
        chk("R10 other sink idle", (dir == 2) ? usb_tx_valid : sd_tx_valid, 0);
        i++;
      end
      @(negedge clk);
      cyc++;
    end
    sd_tx_ready = 1'b0; usb_tx_ready = 1'b0;
    chk("R7 bytes sent", i, count);
  endtask

  task automatic run_xfer(int dir, int len, int base);
    logic [31:0] r;
    int n, ba;
    n  = (len + 1) << BLK;
    ba = base << UNIT;
    wr(8'h08, 32'(len));
    wr(8'h0C, 32'(base));
    wr(8'h14, 32'(dir));
    rd(8'h04, r);
    chk("R5 busy after command", r[15:0], stat(1'b1, 1'b0));
    if (dir == 1 || dir == 3) feed_in(dir, 0, n, ba);
    else drain_out(dir, n, ba);
    rd(8'h04, r);
    chk("R11 idle after last byte", r[15:0], stat(1'b0, 1'b0));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got hung expected done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] r;
    bus_addr = 8'h04;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    rd(8'h04, r); chk("R1 status locked read", r, 0);
    rd(8'h2C, r); chk("R1 version locked read", r, 0);
    // R3 locked writes ignored
    wr(8'h08, 32'h0000_0055);
    wr(8'h14, 32'd1);
    wr(8'h20, 32'h0000_1234);
    rd(8'h08, r); chk("R3 len unchanged", r, {stat(1'b0, 1'b0), 16'h0000});
    rd(8'h04, r); chk("R3 no start while locked", r[0], 0);
    // R4 readback and version
    rd(8'h2C, r); chk("R4 version", r, {stat(1'b0, 1'b0), 16'h0304});
    wr(8'h2C, 32'h0000_FFFF);
    rd(8'h2C, r); chk("R4 version read-only", r[15:0], 16'h0304);
    wr(8'h08, 32'hABCD_7E11);
    rd(8'h08, r); chk("R4 len readback", r, {stat(1'b0, 1'b0), 16'h7E11});
    wr(8'h0C, 32'h0000_0203);
    rd(8'h0C, r); chk("R4 base readback", r, {stat(1'b0, 1'b0), 16'h0203});
    rd(8'h10, r); chk("R4 upper half is status", r, {stat(1'b0, 1'b0), 16'h0000});
    // R5 flag sweep
    for (int f = 0; f < 4; f++) begin
      usb_rxf_n = f[1]; usb_txe_n = f[0];
      rd(8'h04, r); chk("R5 usb flags", r, {2{12'd0, f[1], f[0], 2'b00}});
    end
    usb_rxf_n = 1'b1; usb_txe_n = 1'b0;
    // R2 key behaviour
    wr(8'h20, 32'h0000_5555);
    rd(8'h2C, r); chk("R2 other key value keeps unlock", r[15:0], 16'h0304);
    wr(8'h20, 32'h0000_0000);
    rd(8'h2C, r); chk("R2 zero key locks", r, 0);
    wr(8'h20, 32'h0000_5555);
    rd(8'h2C, r); chk("R2 other key value keeps lock", r, 0);
    wr(8'h20, 32'h0000_1234);
    // R6 invalid codes
    for (int c = 0; c < 8; c++) begin
      if (c >= 1 && c <= 4) continue;
      wr(8'h14, 32'(c));
      rd(8'h04, r); chk("R6 invalid code ignored", r[1:0], 0);
    end
    // sweep of directions, lengths and bases
    for (int d = 1; d <= 4; d++)
      for (int l = 0; l < 3; l++)
        for (int b = 0; b < 3; b++)
          run_xfer(d, l, b);
    // R12 timeout mid-block
    wr(8'h08, 32'd0);
    wr(8'h0C, 32'd1);
    wr(8'h14, 32'd1);
    feed_in(1, 0, 3, 32);
    for (int k = 1; k < TO; k++) begin
      @(negedge clk);
      rd(8'h04, r); chk("R12 busy before limit", r[1:0], 2'b01);
    end
    @(negedge clk);
    rd(8'h04, r); chk("R12 aborted with timeout", r[15:0], stat(1'b0, 1'b1));
    sd_rx_valid = 1'b1;
    #0.5;
    chk("R12 no ready after abort", {sd_rx_ready, mem_we}, 0);
    @(negedge clk);
    sd_rx_valid = 1'b0;
    rd(8'h04, r); chk("R12 flag persists", r[1], 1);
    wr(8'h14, 32'd7);
    rd(8'h04, r); chk("R6 invalid code keeps flag", r[1:0], 2'b10);
    // R13 new command clears flag; command while busy ignored
    wr(8'h14, 32'd1);
    rd(8'h04, r); chk("R13 flag cleared", r[1:0], 2'b01);
    wr(8'h14, 32'd3);
    usb_rx_valid = 1'b1;
    #0.5;
    chk("R13 busy command ignored", usb_rx_ready, 0);
    usb_rx_valid = 1'b0;
    feed_in(1, 0, 1 << BLK, 32);
    rd(8'h04, r); chk("R13 first transfer completes", r[1:0], 2'b00);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule